// File: doc/BRIEF.md
# Clause-22 Management Interface Master

This block runs read and write transactions to an external PHY over a two-wire management interface: a clock line (MDC) and a bidirectional data line (MDIO). Software talks to it through a small register port that has two words: a data word and a command word. For a write, software loads the 16-bit value into the data word and then writes the command word with its busy bit set. For a read, it writes only the command word. It then polls the busy bit. When busy reads zero, the transaction is over, and for a read the returned value sits in the data word.

The command word carries the target PHY and register numbers, a direction flag, a flag that leaves out the 32-bit preamble, and a divider that sets how long each MDC half-period lasts. MDC toggles only while a transaction is in progress and the external enable input is high. Pulling the enable low freezes the transaction where it stands.

Top module: `mdio_master`

## Requirements
- R1: After reset, both register words read as zero, MDC is low and the MDIO output enable is off.
- R2: The command word has these fields: register number in bits 4:0, PHY number in bits 12:8, write flag in bit 16 (1 = write, 0 = read), busy in bit 17, preamble skip in bit 18 and MDC divider in bits 23:20. It reads back as last accepted, with bit 17 showing the live busy state. The data word reads back in bits 15:0.
- R3: A write sends 32 ones, start pattern 01, opcode 01, the PHY number, the register number, turnaround 10 and then the 16 data bits. Every field goes out MSB first, and the output enable stays on for every bit.
- R4: A read sends 32 ones, 01, opcode 10, the PHY number and the register number with the output enable on. The enable is then off for the 2 turnaround bits and the 16 data bits. The 16 bits sampled from MDIO, MSB first, land in data word bits 15:0.
- R5: With bit 18 set, the preamble is left out and the frame is 32 MDC periods long instead of 64.
- R6: Each MDC half-period lasts divider+1 system clocks.
- R7: Writing the command word with bit 17 set starts a transaction. Busy reads 1 until the frame ends and then returns to 0. Read data is already in place when busy first reads 0.
- R8: Writes to either register word while busy is set have no effect.
- R9: MDC holds its level and the transaction does not advance while the enable input is low. It resumes when the enable goes high again.
- R10: MDIO output changes only while MDC is low, and it is sampled on the MDC rising edge. Between transactions MDC is low and the output enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 data word, 1 command word |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Registered read data for the word selected in the previous cycle |
| mdc_enable | input | 1 | Allows MDC to run |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest states to reach from the ports are a transaction frozen partway through by the enable input, and a command or data write that arrives while a frame is already on the wire. The bench gets to the first by counting MDC rising edges from its PHY model and dropping the enable after the tenth. It then watches that neither the edge count nor the MDC level moves. It gets to the second by issuing a conflicting command and a new data value straight after a write has started. It then confirms from the captured frame and from the readback that the original values were kept. The PHY model answers reads bit by bit after each MDC falling edge, so turnaround release and data capture are checked against the frame position. The preamble-skip offset is included in that check.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;
  localparam int DAT_POS   = 48;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DIV_W     = 4;
  localparam int DAT_W     = 16;
  localparam int FLD_W     = 5;

  // command word bit positions (software visible)
  localparam int C_REG_LSB = 0;
  localparam int C_PHY_LSB = 8;
  localparam int C_WR      = 16;
  localparam int C_BUSY    = 17;
  localparam int C_NOPRE   = 18;
  localparam int C_DIV_LSB = 20;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             nopre;
    logic             wr;
    logic [FLD_W-1:0] phy;
    logic [FLD_W-1:0] regad;
  } mdio_cmd_t;

  // full frame, bit FRAME_LEN-1 leaves first
  function automatic logic [FRAME_LEN-1:0] mk_frame(input logic wr,
                                                    input logic [FLD_W-1:0] phy,
                                                    input logic [FLD_W-1:0] ra,
                                                    input logic [DAT_W-1:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    op = wr ? 2'b01 : 2'b10;
    ta = wr ? 2'b10 : 2'b11;
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, ra, ta, (wr ? d : {DAT_W{1'b1}})};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             edge_now;

  assign edge_now = active && run && (cnt == div);
  assign rise     = edge_now && !mdc;
  assign fall     = edge_now && mdc;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (run) begin
      if (cnt == div) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mdio_cmd_t        new_cmd,
  input  logic [DAT_W-1:0] tx_data,
  input  logic             rise,
  input  logic             fall,
  input  logic             mdio_i,
  output logic             active,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done,
  output logic [DAT_W-1:0] rx_data
);
  logic [FRAME_LEN-1:0] frame_q;
  logic [FRAME_LEN-1:0] frame_new;
  logic [IDX_W-1:0]     idx;
  logic                 is_wr;

  assign frame_new = mk_frame(new_cmd.wr, new_cmd.phy, new_cmd.regad, tx_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      idx     <= '0;
      is_wr   <= 1'b0;
      active  <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        is_wr   <= new_cmd.wr;
        rx_data <= '0;
        mdio_oe <= 1'b1;
        if (new_cmd.nopre) begin
          frame_q <= {frame_new[FRAME_LEN-PRE_LEN-1:0], {PRE_LEN{1'b0}}};
          idx     <= IDX_W'(PRE_LEN);
          mdio_o  <= frame_new[FRAME_LEN-PRE_LEN-1];
        end else begin
          frame_q <= frame_new;
          idx     <= '0;
          mdio_o  <= frame_new[FRAME_LEN-1];
        end
      end else if (active) begin
        if (rise && !is_wr && (int'(idx) >= DAT_POS))
          rx_data <= {rx_data[DAT_W-2:0], mdio_i};
        if (fall) begin
          if (int'(idx) == FRAME_LEN-1) begin
            active  <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            done    <= 1'b1;
          end else begin
            idx     <= idx + 1'b1;
            frame_q <= frame_q << 1;
            mdio_o  <= frame_q[FRAME_LEN-2];
            mdio_oe <= is_wr || ((int'(idx) + 1) < TA_POS);
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             done,
  input  logic [DAT_W-1:0] rx_data,
  output logic             start,
  output mdio_cmd_t        cmd_next,
  output mdio_cmd_t        cmd_q,
  output logic [DAT_W-1:0] data_q,
  output logic             busy
);
  logic [BUS_W-1:0] cmd_word;
  logic             accept;

  assign accept = bus_wr && !busy;
  assign start  = accept && bus_addr && bus_wdata[C_BUSY];

  always_comb begin
    cmd_next.div   = bus_wdata[C_DIV_LSB +: DIV_W];
    cmd_next.nopre = bus_wdata[C_NOPRE];
    cmd_next.wr    = bus_wdata[C_WR];
    cmd_next.phy   = bus_wdata[C_PHY_LSB +: FLD_W];
    cmd_next.regad = bus_wdata[C_REG_LSB +: FLD_W];
  end

  always_comb begin
    cmd_word                        = '0;
    cmd_word[C_DIV_LSB +: DIV_W]    = cmd_q.div;
    cmd_word[C_NOPRE]               = cmd_q.nopre;
    cmd_word[C_BUSY]                = busy;
    cmd_word[C_WR]                  = cmd_q.wr;
    cmd_word[C_PHY_LSB +: FLD_W]    = cmd_q.phy;
    cmd_word[C_REG_LSB +: FLD_W]    = cmd_q.regad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      data_q    <= '0;
      busy      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (done) begin
        busy <= 1'b0;
        if (!cmd_q.wr) data_q <= rx_data;
      end
      if (accept) begin
        if (bus_addr) begin
          cmd_q <= cmd_next;
          busy  <= bus_wdata[C_BUSY];
        end else begin
          data_q <= bus_wdata[DAT_W-1:0];
        end
      end
      bus_rdata <= bus_addr ? cmd_word : BUS_W'(data_q);
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             mdc_enable,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  mdio_cmd_t        cmd_next;
  mdio_cmd_t        cmd_q;
  logic [DAT_W-1:0] data_q;
  logic [DAT_W-1:0] rx_data;
  logic             start;
  logic             busy;
  logic             done;
  logic             active;
  logic             rise;
  logic             fall;
  logic             lat_wr;
  logic [FLD_W-1:0] lat_phy;

  assign lat_wr  = cmd_q.wr;
  assign lat_phy = cmd_q.phy;

  mdio_regs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
    .rx_data(rx_data), .start(start), .cmd_next(cmd_next), .cmd_q(cmd_q),
    .data_q(data_q), .busy(busy)
  );

  mdio_clkgen u_clk (
    .clk(clk), .rst(rst), .active(active), .run(mdc_enable),
    .div(cmd_q.div), .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst(rst), .start(start), .new_cmd(cmd_next),
    .tx_data(data_q), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .active(active), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
    .rx_data(rx_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       mdc_enable,
  input logic       busy,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic       lat_wr,
  input logic [4:0] lat_phy
);
  AST_MDC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !mdc_enable |=> $stable(mdc)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && !mdc)); // R10
  AST_MDIO_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc); // R10
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    ($rose(mdc) && lat_wr) |-> mdio_oe); // R3
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr) |=> ($stable(lat_phy) && $stable(lat_wr))); // R8
  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdc) |-> busy); // R7
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .mdc_enable(mdc_enable), .busy(busy), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .lat_wr(lat_wr), .lat_phy(lat_phy)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int PERIOD = 4;
  localparam int NV = 5;
  // {wr, nopre, div[3:0], phy[4:0], reg[4:0], data[15:0]}
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd3,  5'd1,  5'd0,  16'hA5C3},
    {1'b0, 1'b0, 4'd2,  5'd31, 5'd1,  16'h1234},
    {1'b1, 1'b1, 4'd0,  5'd16, 5'd31, 16'h8001},
    {1'b0, 1'b1, 4'd10, 5'd5,  5'd4,  16'h0F0F},
    {1'b0, 1'b0, 4'd0,  5'd0,  5'd30, 16'h8001}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc_enable = 1'b1;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc_enable(mdc_enable),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model
  int          nrise = 0;
  int          base = 0;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  logic [15:0] phy_word = '0;
  time         last_rise_t = 0;
  int          hp_meas = 0;

  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_o};
    oecap = {oecap[62:0], mdio_oe};
    nrise++;
    last_rise_t = $time;
  end

  always @(negedge mdc) begin
    int ix;
    hp_meas = int'(($time - last_rise_t) / PERIOD);
    ix = base + nrise;
    if (ix >= 48 && ix <= 63) mdio_i = phy_word[63-ix];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic wr, input logic nopre,
      input logic [3:0] div, input logic [4:0] phy, input logic [4:0] ra,
      input logic busy);
    return {8'h00, div, 1'b0, nopre, busy, wr, 3'b000, phy, 3'b000, ra};
  endfunction

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
      input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, d};
  endfunction

  task automatic prep(input logic nopre, input logic [15:0] pw);
    base = nopre ? 32 : 0;
    nrise = 0; cap = '0; oecap = '0; mdio_i = 1'b1; phy_word = pw;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] r;
    ok = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      bus_read(1'b1, r);
      if (!r[17]) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    #(PERIOD*150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(1'b0, r); chk(r == 0, "R1 data word", r, 0);
    bus_read(1'b1, r); chk(r == 0, "R1 command word", r, 0);
    chk(mdc == 0 && mdio_oe == 0, "R1 pins", {mdc, mdio_oe}, 0);

    // table-driven transactions
    for (int i = 0; i < NV; i++) begin
      logic        wr, nopre;
      logic [3:0]  div;
      logic [4:0]  phy, ra;
      logic [15:0] d;
      logic [63:0] ex, mask, oexp;
      string       tag;
      {wr, nopre, div, phy, ra, d} = VEC[i];
      tag = nopre ? "R5" : (wr ? "R3" : "R4");
      prep(nopre, d);
      if (wr) bus_write(1'b0, {16'h0, d});
      bus_write(1'b1, cmd_word(wr, nopre, div, phy, ra, 1'b1));
      bus_read(1'b1, r);
      chk(r[17] == 1'b1, "R7 busy set", r, 1);
      wait_idle(ok);
      chk(ok, "R7 busy clears", ok, 1);
      chk(nrise == (nopre ? 32 : 64), {tag, " frame length"}, nrise, nopre ? 32 : 64);
      ex = exp_frame(wr, phy, ra, d);
      mask = '0; oexp = '0;
      for (int b = base; b < 64; b++) begin
        if (wr || b < 46) mask[63-b] = 1'b1;
        oexp[63-b] = wr || (b < 46);
      end
      chk(((cap ^ ex) & mask) == 0, {tag, " frame bits"}, cap & mask, ex & mask);
      chk((oecap & ((64'h1 << (64 - base)) - 1)) == oexp, {tag, " output enable"},
          oecap, oexp);
      if (!wr) begin
        bus_read(1'b0, r);
        chk(r == {16'h0, d}, "R4 read data", r, {16'h0, d});
      end
      chk(hp_meas == int'(div) + 1, "R6 half period", hp_meas, int'(div) + 1);
      bus_read(1'b1, r);
      chk(r == cmd_word(wr, nopre, div, phy, ra, 1'b0), "R2 readback", r,
          cmd_word(wr, nopre, div, phy, ra, 1'b0));
      chk(mdc == 0 && mdio_oe == 0, "R10 idle pins", {mdc, mdio_oe}, 0);
    end

    // R8: writes during busy have no effect
    prep(1'b0, 16'h0000);
    bus_write(1'b0, 32'h1111);
    bus_write(1'b1, cmd_word(1'b1, 1'b0, 4'd1, 5'd3, 5'd2, 1'b1));
    bus_write(1'b1, cmd_word(1'b0, 1'b1, 4'd0, 5'd7, 5'd9, 1'b1));
    bus_write(1'b0, 32'h2222);
    wait_idle(ok);
    chk(cap[15:0] == 16'h1111, "R8 frame data kept", cap[15:0], 16'h1111);
    chk(nrise == 64, "R8 no second frame", nrise, 64);
    bus_read(1'b1, r);
    chk(r == cmd_word(1'b1, 1'b0, 4'd1, 5'd3, 5'd2, 1'b0), "R8 command kept", r,
        cmd_word(1'b1, 1'b0, 4'd1, 5'd3, 5'd2, 1'b0));
    bus_read(1'b0, r);
    chk(r == 32'h1111, "R8 data kept", r, 32'h1111);

    // R9: enable low holds MDC, both before and in the middle of a frame
    prep(1'b0, 16'h0000);
    mdc_enable = 1'b0;
    bus_write(1'b0, 32'h5A5A);
    bus_write(1'b1, cmd_word(1'b1, 1'b0, 4'd0, 5'd2, 5'd3, 1'b1));
    repeat (50) @(negedge clk);
    chk(mdc == 0 && nrise == 0, "R9 no clock while disabled", nrise, 0);
    bus_read(1'b1, r);
    chk(r[17] == 1'b1, "R9 still busy", r, 1);
    mdc_enable = 1'b1;
    while (nrise < 10) @(posedge mdc);
    @(negedge clk);
    mdc_enable = 1'b0;
    begin
      int  n0;
      logic m0;
      n0 = nrise; m0 = mdc;
      repeat (30) @(negedge clk);
      chk(nrise == n0 && mdc == m0, "R9 frozen mid frame", nrise, n0);
    end
    mdc_enable = 1'b1;
    wait_idle(ok);
    chk(ok && nrise == 64, "R9 resumes to completion", nrise, 64);
    chk(cap == exp_frame(1'b1, 5'd2, 5'd3, 16'h5A5A), "R9 frame intact", cap,
        exp_frame(1'b1, 5'd2, 5'd3, 16'h5A5A));
    chk(mdc == 0 && mdio_oe == 0, "R10 idle after stall", {mdc, mdio_oe}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule